// File: doc/BRIEF.md
# Two-dimensional DMA address generator

This block produces the word addresses for one DMA channel that reads a rectangular window out of memory. Memory is treated as a run of equal-length lines whose length (the pitch) is programmed. Software sets a base address, a per-line beat count (X length), a line count selector (Y length) and the pitch, then pulses a start command. The block walks the window line by line and offers one address per beat on a valid/ready request port. It pulses a completion flag when the last beat has been taken. A stop command aborts the walk at once.

Back-pressure rules for the request port are as follows. The block raises `req_valid` with an address and holds both unchanged until a cycle in which `req_ready` is also high. Only such a cycle consumes the address. `req_ready` may be driven low for any number of cycles. The block never withdraws a valid address, except when a stop command aborts the transfer. The channel serves a single fixed peripheral, so the request port carries no channel tag.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `req_valid`, `busy` and `done` are low.
- R2: Beat x (0 ≤ x < X length) of line n is issued at address (base + n·pitch + x) modulo 2^AW. All beats of a line are issued before the next line starts, in increasing x.
- R3: The transfer covers Y length + 1 lines, so a Y length of zero gives exactly one line of X length beats.
- R4: An X length equal to the pitch yields one contiguous linear run. An X length above the pitch raises no error: each line keeps running linearly, so later lines revisit addresses of earlier ones.
- R5: The address advances only on a cycle where `req_valid` and `req_ready` are both high. While `req_ready` is low, `req_valid` and `req_addr` hold steady.
- R6: `done` is high for exactly one cycle, the cycle after the last beat is accepted. In that same cycle `busy` and `req_valid` are low.
- R7: A `cmd_stop` sampled high makes `busy` and `req_valid` low in the next cycle, with no `done` pulse. Stop wins over a start in the same cycle and over a final beat in the same cycle.
- R8: A `cmd_start` sampled while `busy` is high is ignored. The parameters are captured at start, so later changes on the configuration inputs do not alter a running transfer.
- R9: An X length of zero issues no beats: `busy` stays low and `done` pulses in the cycle after the start.
- R10: Address arithmetic wraps modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | AW | Window base word address |
| cfg_xlen | input | LW | Beats per line |
| cfg_ylen | input | LW | Line count minus one |
| cfg_pitch | input | LW | Line length (pitch) in words |
| cmd_start | input | 1 | Start pulse, captures the configuration when idle |
| cmd_stop | input | 1 | Immediate abort |
| req_valid | output | 1 | Address offered |
| req_ready | input | 1 | Consumer accepts the address |
| req_addr | output | AW | Word address of the current beat |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with AW = 12 and LW = 4. This keeps every combination of X length 0–5, Y length 0–3 and pitch 1–4 in a short sweep, which covers the degenerate single-line case, the abutting case and the spilling case. It runs each combination under both continuous and gapped ready patterns. The 12-bit address space lets a base near the top show the wrap. Stop and ignored-start cases are driven at chosen beats, including the final one.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RUN = 1'b1} walk_state_t;
endpackage

// File: rtl/dma2d_cfg_hold.sv
module dma2d_cfg_hold #(
  parameter int AW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] in_base,
  input  logic [LW-1:0] in_xlen,
  input  logic [LW-1:0] in_ylen,
  input  logic [LW-1:0] in_pitch,
  output logic [LW-1:0] xlen_q,
  output logic [LW-1:0] ylen_q,
  output logic [LW-1:0] pitch_q
);
  // base is consumed directly by the line accumulator at load time
  logic [AW-1:0] unused_base;
  assign unused_base = in_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xlen_q  <= '0;
      ylen_q  <= '0;
      pitch_q <= '0;
    end else if (load) begin
      xlen_q  <= in_xlen;
      ylen_q  <= in_ylen;
      pitch_q <= in_pitch;
    end
  end
endmodule

// File: rtl/dma2d_step_cnt.sv
module dma2d_step_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] lim,
  output logic [W-1:0] cnt,
  output logic         at_lim
);
  assign at_lim = (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (inc)     cnt <= at_lim ? '0 : cnt + W'(1);
  end
endmodule

// File: rtl/dma2d_line_acc.sv
module dma2d_line_acc #(
  parameter int AW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_base,
  input  logic          next_line,
  input  logic [LW-1:0] pitch,
  input  logic [LW-1:0] col,
  output logic [AW-1:0] addr
);
  localparam int PAD = AW - LW;
  logic [AW-1:0] line_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         line_base <= '0;
    else if (load)      line_base <= load_base;
    else if (next_line) line_base <= line_base + {{PAD{1'b0}}, pitch};
  end

  assign addr = line_base + {{PAD{1'b0}}, col};
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_base,
  input  logic [LW-1:0] cfg_xlen,
  input  logic [LW-1:0] cfg_ylen,
  input  logic [LW-1:0] cfg_pitch,
  input  logic          cmd_start,
  input  logic          cmd_stop,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic          busy,
  output logic          done
);
  walk_state_t   state_q;
  logic          load, accept, col_last, row_last, finish;
  logic [LW-1:0] xlen_q, ylen_q, pitch_q, col, row, col_lim;

  assign load    = (state_q == ST_IDLE) && cmd_start && !cmd_stop;
  assign accept  = (state_q == ST_RUN) && req_ready;
  assign col_lim = xlen_q - LW'(1);
  assign finish  = accept && col_last && row_last;

  dma2d_cfg_hold #(.AW(AW), .LW(LW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(load),
    .in_base(cfg_base), .in_xlen(cfg_xlen), .in_ylen(cfg_ylen), .in_pitch(cfg_pitch),
    .xlen_q(xlen_q), .ylen_q(ylen_q), .pitch_q(pitch_q)
  );

  dma2d_step_cnt #(.W(LW)) u_col (
    .clk(clk), .rst_n(rst_n), .clr(load), .inc(accept),
    .lim(col_lim), .cnt(col), .at_lim(col_last)
  );

  dma2d_step_cnt #(.W(LW)) u_row (
    .clk(clk), .rst_n(rst_n), .clr(load), .inc(accept && col_last),
    .lim(ylen_q), .cnt(row), .at_lim(row_last)
  );

  dma2d_line_acc #(.AW(AW), .LW(LW)) u_acc (
    .clk(clk), .rst_n(rst_n), .load(load), .load_base(cfg_base),
    .next_line(accept && col_last), .pitch(pitch_q), .col(col), .addr(req_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cmd_stop) begin
        state_q <= ST_IDLE;
      end else if (load) begin
        if (cfg_xlen == '0) done <= 1'b1;
        else                state_q <= ST_RUN;
      end else if (finish) begin
        state_q <= ST_IDLE;
        done    <= 1'b1;
      end
    end
  end

  assign busy      = (state_q == ST_RUN);
  assign req_valid = busy;
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_start,
  input logic          cmd_stop,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          busy,
  input logic          done
);
  // R5
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !cmd_stop |=> req_valid && $stable(req_addr));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !req_valid);
  // R7
  stop_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> !busy && !req_valid && !done);
  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_start && !cmd_stop && !req_ready |=> busy && $stable(req_addr));
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .busy(busy), .done(done)
);

// File: tb/dma2d_addr_gen_bench.sv
module dma2d_addr_gen_bench;
  localparam int AW = 12;
  localparam int LW = 4;
  localparam int CLK_PERIOD = 10;
  localparam int SPACE = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [LW-1:0] cfg_xlen = '0, cfg_ylen = '0, cfg_pitch = '0;
  logic          cmd_start = 1'b0, cmd_stop = 1'b0, req_ready = 1'b0;
  logic          req_valid, busy, done;
  logic [AW-1:0] req_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  dma2d_addr_gen #(.AW(AW), .LW(LW)) u_dma2d_addr_gen (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_xlen(cfg_xlen),
    .cfg_ylen(cfg_ylen), .cfg_pitch(cfg_pitch), .cmd_start(cmd_start),
    .cmd_stop(cmd_stop), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_addr(int s, int x, int w, int idx);
    return (s + (idx / x) * w + (idx % x)) % SPACE;
  endfunction

  // Full transfer: checks R2/R3/R4/R5/R10 per cycle, R6/R9 at the end,
  // and R8 when poke is set (junk start while busy).
  task automatic run_xfer(int s, int x, int y, int w, int mode, bit poke);
    int total, idx, cyc;
    @(negedge clk);
    cfg_base = AW'(s); cfg_xlen = LW'(x); cfg_ylen = LW'(y); cfg_pitch = LW'(w);
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    total = x * (y + 1);
    idx = 0; cyc = 0;
    while (idx < total && cyc < 4000) begin
      check("R5 valid held", int'(req_valid), 1);
      check("R2 address", int'(req_addr), exp_addr(s, x, w, idx));
      if (poke && cyc == 2) begin
        cfg_base = AW'(s + 77); cfg_xlen = LW'(x + 3); cfg_pitch = LW'(w + 5);
        cmd_start = 1'b1;
      end else cmd_start = 1'b0;
      req_ready = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
      if (req_ready) idx++;
      cyc++;
      @(negedge clk);
    end
    req_ready = 1'b0; cmd_start = 1'b0;
    check("R6 done after last beat", int'(done), 1);
    check("R6 busy low at done", int'(busy), 0);
    check("R3 no extra beat", int'(req_valid), 0);
    @(negedge clk);
    check("R6 done single cycle", int'(done), 0);
    check("R3 stays idle", int'(req_valid), 0);
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 valid at reset", int'(req_valid), 0);
    check("R1 busy at reset", int'(busy), 0);
    check("R1 done at reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", int'(busy), 0);

    // Sweep: R2 R3 R4 R5 R8 R9
    n = 0;
    for (int x = 0; x <= 5; x++)
      for (int y = 0; y <= 3; y++)
        for (int w = 1; w <= 4; w++) begin
          run_xfer((n * 37) % SPACE, x, y, w, (x + y + w) % 2, (n % 3) == 0);
          n++;
        end

    // R9: zero X length, busy never rises
    run_xfer(100, 0, 3, 2, 0, 1'b0);
    // R4: X length equal to pitch and above pitch (overlap), stalled
    run_xfer(200, 4, 3, 4, 1, 1'b0);
    run_xfer(300, 6, 2, 2, 1, 1'b1);
    // R10: wrap at top of address space
    run_xfer(SPACE - 3, 4, 2, 3, 1, 1'b0);

    // R7: stop mid-transfer
    @(negedge clk);
    cfg_base = 12'd50; cfg_xlen = 4'd5; cfg_ylen = 4'd2; cfg_pitch = 4'd5;
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0; req_ready = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 still busy before stop", int'(busy), 1);
    cmd_stop = 1'b1;
    @(negedge clk);
    cmd_stop = 1'b0; req_ready = 1'b0;
    check("R7 busy cleared by stop", int'(busy), 0);
    check("R7 valid cleared by stop", int'(req_valid), 0);
    check("R7 no done on stop", int'(done), 0);
    @(negedge clk);
    check("R7 no late done", int'(done), 0);

    // R7: stop together with the final beat
    cfg_xlen = 4'd1; cfg_ylen = 4'd0; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    check("R7 single beat offered", int'(req_valid), 1);
    req_ready = 1'b1; cmd_stop = 1'b1;
    @(negedge clk);
    req_ready = 1'b0; cmd_stop = 1'b0;
    check("R7 stop beats final done", int'(done), 0);
    check("R7 idle after final stop", int'(busy), 0);

    // R7: stop together with start while idle
    cmd_start = 1'b1; cmd_stop = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0; cmd_stop = 1'b0;
    check("R7 stop wins over start", int'(busy), 0);
    check("R7 no done from suppressed start", int'(done), 0);

    // Restart after abort works from the new base
    run_xfer(400, 3, 1, 8, 0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule